// File: doc/BRIEF.md
# Bipolar Line Decoder with Violation and Alarm Detection

This block sits behind a line receiver. It accepts one received symbol per bit period as two rails, one carrying positive marks and one carrying negative marks, qualified by a single-cycle bit enable from clock recovery. It turns these into unipolar NRZ data. Every symbol passes through an eight-slot delay line, so the decoded bit appears a fixed number of bit periods later in every mode. While a symbol is in the delay line, the block can spot a zero-substitution pattern and mark its pulses as stand-ins for zeros.

Four receive modes are available. Transparent mode simply ORs the two rails. AMI mode decodes each mark as a one and reports polarity errors. Two substitution modes work like AMI but also remove the eight-zero or four-zero replacement patterns. Whenever a non-substituted violation leaves the delay line, the block raises a violation strobe for one bit period. It also sets a sticky status bit that stays set until a clear input removes it. A window monitor counts decoded zeros and raises an alarm when the line carries almost nothing but ones.

Top module: `bipolar_decoder`

## Requirements
- R1: `mode` is encoded as 00 transparent, 01 AMI, 10 eight-zero substitution (B8ZS), 11 four-zero substitution (HDB3). In transparent mode `rx_data` is the OR of both rails, `bpv_strobe` never rises and `ais_alarm` is low.
- R2: A symbol sampled on a bit-enable edge appears on `rx_data` exactly 8 bit-enable edges later, in every mode. `rx_data` and `bpv_strobe` change only on bit-enable edges.
- R3: In AMI mode, a pulse on either rail decodes to 1 and no pulse decodes to 0.
- R4: In the coder modes (01, 10, 11), a mark with the same polarity as the previous mark is a violation. `bpv_strobe` is 1 for the bit period in which that mark is presented on `rx_data` (as a 1), and 0 otherwise. The first mark after reset is never a violation.
- R5: Pulses on both rails in one bit period decode to 1, count as a violation in the coder modes, and leave the polarity reference unchanged.
- R6: In mode 10, the pattern 0,0,0,V,B,0,V,B is decoded as eight zeros without any strobe. Here V has the polarity of the previous mark and each B is opposite to the V before it. In mode 01 the same input yields 0,0,0,1,1,0,1,1 with strobes on both V positions.
- R7: In mode 11, the patterns 0,0,0,V (V same polarity as the previous mark) and B,0,0,V (B opposite to the previous mark, V equal to B) decode to four zeros without any strobe.
- R8: `bpv_sticky` is set on every edge that raises a strobe and holds until `viol_clr` is high. A new violation on the same edge as `viol_clr` leaves it set.
- R9: Bit periods since reset are grouped into windows of 2048. At the end of each window, `ais_alarm` becomes 1 if that window's decoded output held fewer than 3 zeros and 0 otherwise. The alarm is forced low in transparent mode.
- R10: During and right after reset, `rx_data`, `bpv_strobe`, `bpv_sticky` and `ais_alarm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per received bit period |
| rx_pos | input | 1 | Positive-rail mark for the current bit |
| rx_neg | input | 1 | Negative-rail mark for the current bit |
| mode | input | 2 | Receive mode: 00 transparent, 01 AMI, 10 B8ZS, 11 HDB3 |
| viol_clr | input | 1 | Clears the sticky violation bit |
| rx_data | output | 1 | Decoded NRZ data, 8 bit periods behind the input |
| bpv_strobe | output | 1 | Violation flag for the bit now on rx_data |
| bpv_sticky | output | 1 | Latched violation status |
| ais_alarm | output | 1 | All-ones alarm |

## Verification
If the polarity reference is wrong, the very next legal mark shows up as a false strobe. That strobe lands exactly eight bit periods after the mark enters, and the sticky bit sets on the same edge. If a substitution match is missed or mis-aligned, ones or strobes appear in the middle of an expected run of eight zeros, again eight bit periods after the pattern completes. Window or zero-count errors only show at window boundaries, so a wrong alarm can go unseen for up to one full window of 2048 bit periods. The directed scenarios therefore check the alarm only after several whole windows of a known zero density have passed.

// File: rtl/bpd_pkg.sv
// Shared types for the bipolar decoder.
// Assumes: one slot per received bit period, polarity 0 = positive rail.
package bpd_pkg;

    typedef enum logic [1:0] {
        MODE_TRANSP = 2'b00,
        MODE_AMI    = 2'b01,
        MODE_B8ZS   = 2'b10,
        MODE_HDB3   = 2'b11
    } bpd_mode_e;

    // One received symbol held in the delay line
    typedef struct packed {
        logic mark;   // a pulse on at least one rail
        logic both;   // pulses on both rails
        logic pol;    // 0 positive, 1 negative (valid when mark and not both)
        logic sub;    // pulse belongs to a recognised substitution
    } bpd_slot_t;

    // A clean single-rail pulse that is not yet part of a substitution
    function automatic logic slot_single(input bpd_slot_t s);
        return s.mark && !s.both && !s.sub;
    endfunction

    function automatic logic slot_empty(input bpd_slot_t s);
        return !s.mark;
    endfunction

endpackage

// File: rtl/bpd_subst_match.sv
// Combinational search for zero-substitution patterns in the delay line.
// Slot 0 is the newest symbol, slot DEPTH-1 the oldest.
// Assumes DEPTH >= 8. p_ref is the polarity of the last pulse that has
// already left the line.
module bpd_subst_match
    import bpd_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter bit HAS_B8ZS = 1'b1,
    parameter bit HAS_HDB3 = 1'b1
) (
    input  bpd_slot_t [DEPTH-1:0] line,
    input  logic                  p_ref,
    input  logic                  en_b8zs,
    input  logic                  en_hdb3,
    output logic [DEPTH-1:0]      sub_mask
);

    localparam int HD_SPAN = 4;
    localparam logic [DEPTH-1:0] B8_BITS = DEPTH'(8'b0001_1011);
    localparam logic [DEPTH-1:0] HD_V    = DEPTH'(4'b0001);
    localparam logic [DEPTH-1:0] HD_BV   = DEPTH'(4'b1001);

    logic [DEPTH-1:0] mask_b8;
    logic [DEPTH-1:0] mask_hd;

    generate
        if (HAS_B8ZS) begin : g_b8
            logic hit8;
            // Eight-zero pattern: empties at 7,6,5,2; V,B at 4,3; V,B at 1,0
            always_comb begin
                hit8 = slot_empty(line[7]) && slot_empty(line[6]) &&
                       slot_empty(line[5]) && slot_empty(line[2]) &&
                       slot_single(line[4]) && (line[4].pol == p_ref) &&
                       slot_single(line[3]) && (line[3].pol != p_ref) &&
                       slot_single(line[1]) && (line[1].pol != p_ref) &&
                       slot_single(line[0]) && (line[0].pol == p_ref);
                mask_b8 = (en_b8zs && hit8) ? B8_BITS : '0;
            end
        end else begin : g_no_b8
            assign mask_b8 = '0;
        end

        if (HAS_HDB3) begin : g_hd
            logic prev_pol;
            logic hit_v;
            logic hit_bv;
            // Four-zero patterns: 0,0,0,V and B,0,0,V in slots 3..0
            always_comb begin
                prev_pol = p_ref;
                for (int i = DEPTH - 1; i >= HD_SPAN; i--) begin
                    if (line[i].mark && !line[i].both) prev_pol = line[i].pol;
                end
                hit_v  = slot_empty(line[3]) && slot_empty(line[2]) &&
                         slot_empty(line[1]) && slot_single(line[0]) &&
                         (line[0].pol == prev_pol);
                hit_bv = slot_single(line[3]) && (line[3].pol != prev_pol) &&
                         slot_empty(line[2]) && slot_empty(line[1]) &&
                         slot_single(line[0]) && (line[0].pol == line[3].pol);
                if (!en_hdb3)    mask_hd = '0;
                else if (hit_v)  mask_hd = HD_V;
                else if (hit_bv) mask_hd = HD_BV;
                else             mask_hd = '0;
            end
        end else begin : g_no_hd
            assign mask_hd = '0;
        end
    endgenerate

    assign sub_mask = mask_b8 | mask_hd;

endmodule

// File: rtl/bpd_delay_line.sv
// Fixed-length symbol delay line. New symbols enter at slot 0. Any
// substitution found after the shift tags its pulses before storage.
// Assumes bit_en is a single-cycle strobe per bit period.
module bpd_delay_line
    import bpd_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter bit HAS_B8ZS = 1'b1,
    parameter bit HAS_HDB3 = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_en,
    input  logic      rx_pos,
    input  logic      rx_neg,
    input  logic      p_ref,
    input  logic      en_b8zs,
    input  logic      en_hdb3,
    output bpd_slot_t head
);

    bpd_slot_t [DEPTH-1:0] line_q;
    bpd_slot_t [DEPTH-1:0] shifted;
    bpd_slot_t [DEPTH-1:0] line_d;
    bpd_slot_t             in_slot;
    logic [DEPTH-1:0]      sub_mask;

    // Encode the two rails into a slot and form the shifted line
    always_comb begin
        in_slot.mark = rx_pos | rx_neg;
        in_slot.both = rx_pos & rx_neg;
        in_slot.pol  = rx_neg & ~rx_pos;
        in_slot.sub  = 1'b0;
        shifted      = {line_q[DEPTH-2:0], in_slot};
    end

    bpd_subst_match #(
        .DEPTH    (DEPTH),
        .HAS_B8ZS (HAS_B8ZS),
        .HAS_HDB3 (HAS_HDB3)
    ) u_match (
        .line     (shifted),
        .p_ref    (p_ref),
        .en_b8zs  (en_b8zs),
        .en_hdb3  (en_hdb3),
        .sub_mask (sub_mask)
    );

    // Tag matched pulses as substituted
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            line_d[i]     = shifted[i];
            line_d[i].sub = shifted[i].sub | sub_mask[i];
        end
    end

    // Advance the line once per bit period
    always_ff @(posedge clk) begin
        if (!rst_n)      line_q <= '0;
        else if (bit_en) line_q <= line_d;
    end

    assign head = line_q[DEPTH-1];

endmodule

// File: rtl/bpd_bpv_track.sv
// Decodes the symbol leaving the delay line, tracks the last pulse polarity,
// and drives the violation strobe and sticky status.
// Assumes: substituted pulses still update the polarity reference.
module bpd_bpv_track
    import bpd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_en,
    input  logic      coder_on,
    input  logic      viol_clr,
    input  bpd_slot_t head,
    output logic      p_next,
    output logic      dec_bit,
    output logic      data_q,
    output logic      strobe_q,
    output logic      sticky_q
);

    logic pol_q;
    logic seen_q;
    logic viol;

    // Next polarity reference, decoded bit and violation decision
    always_comb begin
        p_next  = (head.mark && !head.both) ? head.pol : pol_q;
        dec_bit = head.mark && !head.sub;
        viol    = coder_on && head.mark && !head.sub &&
                  (head.both || (seen_q && (head.pol == pol_q)));
    end

    // Polarity reference and first-pulse flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= 1'b0;
            seen_q <= 1'b0;
        end else if (bit_en && head.mark && !head.both) begin
            pol_q  <= head.pol;
            seen_q <= 1'b1;
        end
    end

    // Output data and one-bit-period strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else if (bit_en) begin
            data_q   <= dec_bit;
            strobe_q <= viol;
        end
    end

    // Sticky status: a new violation wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)               sticky_q <= 1'b0;
        else if (bit_en && viol)  sticky_q <= 1'b1;
        else if (viol_clr)        sticky_q <= 1'b0;
    end

endmodule

// File: rtl/bpd_ais_mon.sv
// All-ones alarm monitor. It counts decoded zeros over fixed windows of
// bit periods and updates the alarm at each window end.
// Assumes dec_bit is valid on every bit_en.
module bpd_ais_mon #(
    parameter int WIN_LEN  = 2048,
    parameter int ZERO_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic dec_bit,
    input  logic coder_on,
    output logic alarm
);

    localparam int CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int ZW = $clog2(ZERO_MIN + 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(WIN_LEN - 1);
    localparam logic [ZW-1:0] Z_SAT    = ZW'(ZERO_MIN);

    logic [CW-1:0] win_q;
    logic [ZW-1:0] zeros_q;
    logic [ZW-1:0] zeros_d;
    logic          alarm_q;

    // Saturating zero count including the current bit
    always_comb begin
        zeros_d = zeros_q;
        if (!dec_bit && (zeros_q < Z_SAT)) zeros_d = zeros_q + 1'b1;
    end

    // Window position, zero count and alarm decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= '0;
            zeros_q <= '0;
            alarm_q <= 1'b0;
        end else if (bit_en) begin
            if (win_q == WIN_LAST) begin
                win_q   <= '0;
                zeros_q <= '0;
                alarm_q <= (zeros_d < Z_SAT);
            end else begin
                win_q   <= win_q + 1'b1;
                zeros_q <= zeros_d;
            end
        end
    end

    assign alarm = alarm_q & coder_on;

endmodule

// File: rtl/bipolar_decoder.sv
// Top level of the bipolar line decoder. It joins the delay line with
// pattern search, the violation tracker and the all-ones monitor.
// Assumes rails and mode are synchronous to clk and bit_en pulses at
// most once per bit period.
module bipolar_decoder
    import bpd_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int WIN_LEN  = 2048,
    parameter int ZERO_MIN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       rx_pos,
    input  logic       rx_neg,
    input  logic [1:0] mode,
    input  logic       viol_clr,
    output logic       rx_data,
    output logic       bpv_strobe,
    output logic       bpv_sticky,
    output logic       ais_alarm
);

    bpd_mode_e mode_e;
    logic      coder_on;
    logic      en_b8zs;
    logic      en_hdb3;
    logic      p_next;
    logic      dec_bit;
    bpd_slot_t head;

    // Mode decode
    always_comb begin
        mode_e   = bpd_mode_e'(mode);
        coder_on = (mode_e != MODE_TRANSP);
        en_b8zs  = (mode_e == MODE_B8ZS);
        en_hdb3  = (mode_e == MODE_HDB3);
    end

    bpd_delay_line #(
        .DEPTH    (DEPTH),
        .HAS_B8ZS (1'b1),
        .HAS_HDB3 (1'b1)
    ) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .rx_pos  (rx_pos),
        .rx_neg  (rx_neg),
        .p_ref   (p_next),
        .en_b8zs (en_b8zs),
        .en_hdb3 (en_hdb3),
        .head    (head)
    );

    bpd_bpv_track u_bpv (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .coder_on (coder_on),
        .viol_clr (viol_clr),
        .head     (head),
        .p_next   (p_next),
        .dec_bit  (dec_bit),
        .data_q   (rx_data),
        .strobe_q (bpv_strobe),
        .sticky_q (bpv_sticky)
    );

    bpd_ais_mon #(
        .WIN_LEN  (WIN_LEN),
        .ZERO_MIN (ZERO_MIN)
    ) u_ais (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .dec_bit  (dec_bit),
        .coder_on (coder_on),
        .alarm    (ais_alarm)
    );

endmodule

// File: rtl/bpd_checker.sv
// Port-level properties of the bipolar decoder, bound to every instance.
module bpd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic [1:0] mode,
    input logic       viol_clr,
    input logic       rx_data,
    input logic       bpv_strobe,
    input logic       bpv_sticky,
    input logic       ais_alarm
);

    AST_TRANSP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_en) && ($past(mode) == 2'b00)) |-> !bpv_strobe); // R1

    AST_HOLD_BETWEEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> ($stable(rx_data) && $stable(bpv_strobe))); // R2

    AST_STROBE_MARKS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        bpv_strobe |-> rx_data); // R5

    AST_STICKY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_en) && bpv_strobe) |-> bpv_sticky); // R8

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bpv_sticky) && !$past(viol_clr)) |-> bpv_sticky); // R8

    AST_ALARM_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bit_en) && ($past(mode) == mode)) |-> $stable(ais_alarm)); // R9

endmodule

bind bipolar_decoder bpd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .mode       (mode),
    .viol_clr   (viol_clr),
    .rx_data    (rx_data),
    .bpv_strobe (bpv_strobe),
    .bpv_sticky (bpv_sticky),
    .ais_alarm  (ais_alarm)
);

// File: tb/sim_bipolar_decoder.sv
// Directed bench: one task per scenario. Each bit's expected output is
// written down when the bit is sent and compared eight bit periods later.
module sim_bipolar_decoder;

    localparam int WIN = 2048;
    localparam int LAT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_pos = 1'b0;
    logic       rx_neg = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       viol_clr = 1'b0;
    logic       rx_data;
    logic       bpv_strobe;
    logic       bpv_sticky;
    logic       ais_alarm;

    int    n_chk = 0;
    int    n_bad = 0;
    int    nbits = 0;
    bit    exp_d [16];
    bit    exp_v [16];
    string exp_tag [16];
    bit    lastpol = 1'b1;
    bit    exp_sticky = 1'b0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    bipolar_decoder #(.DEPTH(LAT), .WIN_LEN(WIN), .ZERO_MIN(3)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .rx_pos     (rx_pos),
        .rx_neg     (rx_neg),
        .mode       (mode),
        .viol_clr   (viol_clr),
        .rx_data    (rx_data),
        .bpv_strobe (bpv_strobe),
        .bpv_sticky (bpv_sticky),
        .ais_alarm  (ais_alarm)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Send one symbol, record its expectation, check the bit leaving now
    task automatic send_bit(input bit p, input bit q, input bit ed, input bit ev,
                            input string tag, input bit clr);
        int    slot = nbits % 16;
        bit    od = 1'b0;
        bit    ov = 1'b0;
        string otag = "R10";
        exp_d[slot]   = ed;
        exp_v[slot]   = ev;
        exp_tag[slot] = tag;
        if (nbits >= LAT) begin
            od   = exp_d[(nbits - LAT) % 16];
            ov   = exp_v[(nbits - LAT) % 16];
            otag = exp_tag[(nbits - LAT) % 16];
        end
        exp_sticky = ov | (exp_sticky & ~clr);
        @(negedge clk);
        rx_pos = p; rx_neg = q; bit_en = 1'b1; viol_clr = clr;
        @(negedge clk);
        rx_pos = 1'b0; rx_neg = 1'b0; bit_en = 1'b0; viol_clr = 1'b0;
        nbits++;
        check({rx_data, bpv_strobe, bpv_sticky} == {od, ov, exp_sticky}, otag,
              "data/strobe/sticky", {rx_data, bpv_strobe, bpv_sticky},
              {od, ov, exp_sticky});
    endtask

    task automatic tb_space(input string tag);
        send_bit(1'b0, 1'b0, 1'b0, 1'b0, tag, 1'b0);
    endtask

    task automatic tb_pulse(input bit pol, input bit ed, input bit ev, input string tag);
        lastpol = pol;
        send_bit(!pol, pol, ed, ev, tag, 1'b0);
    endtask

    task automatic tb_mark(input string tag);
        tb_pulse(!lastpol, 1'b1, 1'b0, tag);
    endtask

    task automatic tb_flush();
        for (int i = 0; i < LAT; i++) tb_space("R2");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check({rx_data, bpv_strobe, bpv_sticky, ais_alarm} == 4'b0, "R10",
              "outputs in reset", {rx_data, bpv_strobe, bpv_sticky, ais_alarm}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({rx_data, bpv_strobe, bpv_sticky, ais_alarm} == 4'b0, "R10",
              "outputs after reset", {rx_data, bpv_strobe, bpv_sticky, ais_alarm}, 0);
    endtask

    task automatic t_transparent();
        mode = 2'b00;
        tb_pulse(1'b0, 1'b1, 1'b0, "R1");
        tb_pulse(1'b0, 1'b1, 1'b0, "R1");
        tb_space("R1");
        tb_pulse(1'b1, 1'b1, 1'b0, "R1");
        send_bit(1'b1, 1'b1, 1'b1, 1'b0, "R1", 1'b0);
        tb_pulse(1'b1, 1'b1, 1'b0, "R1");
        tb_flush();
        check(ais_alarm == 1'b0, "R1", "alarm in transparent", ais_alarm, 0);
    endtask

    task automatic t_ami();
        mode = 2'b01;
        tb_mark("R3");
        tb_space("R3");
        tb_mark("R3");
        tb_mark("R3");
        tb_space("R3");
        tb_space("R3");
        tb_mark("R2");
        tb_flush();
    endtask

    task automatic t_violation();
        mode = 2'b01;
        tb_mark("R4");
        tb_pulse(lastpol, 1'b1, 1'b1, "R4");
        tb_space("R4");
        tb_mark("R4");
        send_bit(1'b1, 1'b1, 1'b1, 1'b1, "R5", 1'b0);
        tb_mark("R5");
        tb_flush();
    endtask

    task automatic t_b8zs();
        bit pp;
        mode = 2'b10;
        tb_mark("R6");
        pp = lastpol;
        tb_space("R6"); tb_space("R6"); tb_space("R6");
        tb_pulse(pp, 1'b0, 1'b0, "R6");
        tb_pulse(!pp, 1'b0, 1'b0, "R6");
        tb_space("R6");
        tb_pulse(!pp, 1'b0, 1'b0, "R6");
        tb_pulse(pp, 1'b0, 1'b0, "R6");
        tb_mark("R6");
        tb_flush();
        mode = 2'b01;
        tb_mark("R6");
        pp = lastpol;
        tb_space("R6"); tb_space("R6"); tb_space("R6");
        tb_pulse(pp, 1'b1, 1'b1, "R6");
        tb_pulse(!pp, 1'b1, 1'b0, "R6");
        tb_space("R6");
        tb_pulse(!pp, 1'b1, 1'b1, "R6");
        tb_pulse(pp, 1'b1, 1'b0, "R6");
        tb_flush();
    endtask

    task automatic t_hdb3();
        bit xp;
        mode = 2'b11;
        tb_mark("R7");
        xp = lastpol;
        tb_space("R7"); tb_space("R7"); tb_space("R7");
        tb_pulse(xp, 1'b0, 1'b0, "R7");
        tb_mark("R7");
        xp = !lastpol;
        tb_pulse(xp, 1'b0, 1'b0, "R7");
        tb_space("R7"); tb_space("R7");
        tb_pulse(xp, 1'b0, 1'b0, "R7");
        tb_mark("R7");
        tb_flush();
    endtask

    task automatic t_sticky();
        mode = 2'b01;
        send_bit(1'b0, 1'b0, 1'b0, 1'b0, "R8", 1'b1);
        tb_mark("R8");
        tb_pulse(lastpol, 1'b1, 1'b1, "R8");
        for (int i = 0; i < LAT - 1; i++) tb_space("R8");
        send_bit(1'b0, 1'b0, 1'b0, 1'b0, "R8", 1'b1);
        tb_space("R8");
        tb_space("R8");
        send_bit(1'b0, 1'b0, 1'b0, 1'b0, "R8", 1'b1);
        tb_flush();
    endtask

    task automatic t_ais();
        mode = 2'b01;
        for (int i = 0; i < 3 * WIN; i++) tb_mark("R9");
        check(ais_alarm == 1'b1, "R9", "alarm after all-ones windows", ais_alarm, 1);
        mode = 2'b00;
        @(negedge clk);
        check(ais_alarm == 1'b0, "R1", "alarm gated in transparent", ais_alarm, 0);
        mode = 2'b01;
        @(negedge clk);
        check(ais_alarm == 1'b1, "R9", "alarm restored in AMI", ais_alarm, 1);
        for (int i = 0; i < 3 * WIN; i++) begin
            if (i % WIN < 2) tb_space("R9");
            else             tb_mark("R9");
        end
        check(ais_alarm == 1'b1, "R9", "alarm with two zeros per window", ais_alarm, 1);
        for (int i = 0; i < 3 * WIN; i++) begin
            if (i % WIN < 3) tb_space("R9");
            else             tb_mark("R9");
        end
        check(ais_alarm == 1'b0, "R9", "alarm with three zeros per window", ais_alarm, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_ami();
        t_violation();
        t_b8zs();
        t_hdb3();
        t_sticky();
        t_ais();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", nbits, 0);
            finish_run();
        end
    end

endmodule